// File: doc/BRIEF.md
# DRAM Row Buffer Hit Monitor

This block keeps the open-row state of every bank of a DDR3-style DRAM and sorts each accepted request into one of three kinds. A request is a hit when its bank already holds the requested row. It is an empty access when the bank has no open row. It is a conflict when the bank holds some other row. For each request the block gives back the kind, a modelled service latency in clock cycles, and the row commands the request would need. A conflict needs a precharge pulse and then an activate pulse. An empty access needs a single activate pulse. A hit needs no command.

The block runs three saturating counters: accepted requests, hits and conflicts. Software reads these to work out a hit ratio. While the modelled latency of the last request is running, `busy_o` is high and any new request is dropped. Real DRAM timing, refresh and data movement are not modelled.

Top module: `row_hit_monitor`

## Requirements
- R1: A request whose bank holds the same row is a hit. It reports kind 0 (`resp_kind_o` = 2'd0) with latency HIT_LAT (3), and neither `cmd_pre_o` nor `cmd_act_o` pulses.
- R2: A request to a bank with no open row is an empty access. It reports kind 1 with latency EMPTY_LAT (6). `cmd_act_o` pulses for one cycle, in the response cycle, with `cmd_bank_o`/`cmd_row_o` set to the request.
- R3: A request to a bank whose open row differs is a conflict. It reports kind 2 with latency CONF_LAT (10). `cmd_pre_o` pulses in the response cycle and `cmd_act_o` pulses in the next cycle, never both in one cycle.
- R4: Each bank keeps its own open row. Opening a row in one bank never changes how a request to another bank is classified.
- R5: A request is accepted on a rising edge where `req_valid_i` is high and `busy_o` is low. `resp_valid_o` is high for exactly one cycle, the cycle after acceptance.
- R6: `busy_o` is high for exactly the reported latency, counted in cycles from the cycle after acceptance. A request presented while `busy_o` is high is ignored: it gives no response, changes no counter and leaves no bank state.
- R7: `cnt_req_o` counts accepted requests, `cnt_hit_o` counts hits and `cnt_conf_o` counts conflicts. Each value is visible in the response cycle.
- R8: Each counter stops at its all-ones value instead of wrapping.
- R9: `clr_i` zeroes all three counters at the next edge. It takes priority over an increment in the same cycle and leaves the open-row state untouched.
- R10: After reset all banks are empty, the counters are zero, and `busy_o`, `resp_valid_o`, `cmd_pre_o` and `cmd_act_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the counters |
| req_valid_i | input | 1 | Request present |
| req_bank_i | input | BANK_W (3) | Request bank |
| req_row_i | input | ROW_W (14) | Request row |
| busy_o | output | 1 | Modelled latency running; requests are dropped |
| resp_valid_o | output | 1 | Classification result valid (one cycle) |
| resp_kind_o | output | 2 | 0 hit, 1 empty, 2 conflict |
| resp_lat_o | output | LAT_W (4) | Modelled latency in cycles |
| cmd_pre_o | output | 1 | Precharge pulse |
| cmd_act_o | output | 1 | Activate pulse |
| cmd_bank_o | output | BANK_W (3) | Bank of the command |
| cmd_row_o | output | ROW_W (14) | Row of the command |
| cnt_req_o | output | CNT_W (32) | Accepted request count |
| cnt_hit_o | output | CNT_W (32) | Hit count |
| cnt_conf_o | output | CNT_W (32) | Conflict count |

## Verification
The assertions are checked on every cycle. They cover:
- the order of the commands (a precharge is always followed by an activate, and the two never overlap);
- the one-cycle response and how each kind lines up with its latency and commands;
- requests dropped while busy;
- counter monotonicity, saturation and clear.

Some behaviour only the bench scenarios can show. These are the correct classification against the open-row history of each bank, the exact length of the busy window, and the fact that a dropped request leaves no bank state behind. The bench shows them by tracking the open row per bank and replaying mixed hit, empty and conflict traffic.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_EMPTY    = 2'd1,
    KIND_CONFLICT = 2'd2
  } kind_e;
endpackage

// File: rtl/rhm_bank_table.sv
module rhm_bank_table
  import rhm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wr_en_i,
  output kind_e             kind_o
);
  logic             open_q [NUM_BANKS];
  logic [ROW_W-1:0] row_q  [NUM_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end
    end else if (wr_en_i) begin
      open_q[bank_i] <= 1'b1;
      row_q[bank_i]  <= row_i;
    end
  end

  always_comb begin
    if (!open_q[bank_i])             kind_o = KIND_EMPTY;
    else if (row_q[bank_i] == row_i) kind_o = KIND_HIT;
    else                             kind_o = KIND_CONFLICT;
  end
endmodule

// File: rtl/rhm_sat_counter.sv
module rhm_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/rhm_cmd_seq.sv
module rhm_cmd_seq
  import rhm_pkg::*;
#(
  parameter int unsigned HIT_LAT   = 3,
  parameter int unsigned EMPTY_LAT = 6,
  parameter int unsigned CONF_LAT  = 10,
  localparam int unsigned LAT_W    = $clog2(CONF_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  kind_e            kind_i,
  output logic             accept_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             busy_o,
  output logic             pre_o,
  output logic             act_o
);
  logic [LAT_W-1:0] remain_q;

  always_comb begin
    unique case (kind_i)
      KIND_HIT:   lat_o = LAT_W'(HIT_LAT);
      KIND_EMPTY: lat_o = LAT_W'(EMPTY_LAT);
      default:    lat_o = LAT_W'(CONF_LAT);
    endcase
  end

  assign busy_o   = (remain_q != '0);
  assign accept_o = req_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      pre_o    <= 1'b0;
      act_o    <= 1'b0;
    end else begin
      if (accept_o)    remain_q <= lat_o;
      else if (busy_o) remain_q <= remain_q - LAT_W'(1);
      pre_o <= accept_o && (kind_i == KIND_CONFLICT);
      // activate follows precharge by one cycle, or opens an empty bank directly
      act_o <= (accept_o && (kind_i == KIND_EMPTY)) || pre_o;
    end
  end
endmodule

// File: rtl/row_hit_monitor.sv
module row_hit_monitor
  import rhm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned HIT_LAT   = 3,
  parameter int unsigned EMPTY_LAT = 6,
  parameter int unsigned CONF_LAT  = 10,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned LAT_W    = $clog2(CONF_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [1:0]        resp_kind_o,
  output logic [LAT_W-1:0]  resp_lat_o,
  output logic              cmd_pre_o,
  output logic              cmd_act_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [CNT_W-1:0]  cnt_req_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_conf_o
);
  localparam int unsigned NUM_CNT = 3;

  kind_e            kind;
  logic             accept;
  logic [LAT_W-1:0] lat;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  rhm_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bank_i  (req_bank_i),
    .row_i   (req_row_i),
    .wr_en_i (accept),
    .kind_o  (kind)
  );

  rhm_cmd_seq #(.HIT_LAT(HIT_LAT), .EMPTY_LAT(EMPTY_LAT), .CONF_LAT(CONF_LAT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .kind_i      (kind),
    .accept_o    (accept),
    .lat_o       (lat),
    .busy_o      (busy_o),
    .pre_o       (cmd_pre_o),
    .act_o       (cmd_act_o)
  );

  assign inc[0] = accept;
  assign inc[1] = accept && (kind == KIND_HIT);
  assign inc[2] = accept && (kind == KIND_CONFLICT);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rhm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign cnt_req_o  = cnt[0];
  assign cnt_hit_o  = cnt[1];
  assign cnt_conf_o = cnt[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_kind_o  <= 2'd0;
      resp_lat_o   <= '0;
      cmd_bank_o   <= '0;
      cmd_row_o    <= '0;
    end else begin
      resp_valid_o <= accept;
      if (accept) begin
        resp_kind_o <= kind;
        resp_lat_o  <= lat;
        cmd_bank_o  <= req_bank_i;
        cmd_row_o   <= req_row_i;
      end
    end
  end
endmodule

// File: rtl/rhm_checker.sv
module rhm_checker #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned LAT_W     = 4,
  parameter int unsigned HIT_LAT   = 3,
  parameter int unsigned EMPTY_LAT = 6,
  parameter int unsigned CONF_LAT  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             resp_valid_o,
  input logic [1:0]       resp_kind_o,
  input logic [LAT_W-1:0] resp_lat_o,
  input logic             cmd_pre_o,
  input logic             cmd_act_o,
  input logic [CNT_W-1:0] cnt_req_o,
  input logic [CNT_W-1:0] cnt_hit_o,
  input logic [CNT_W-1:0] cnt_conf_o
);
  a_r1_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o == 2'd0 |-> !cmd_pre_o && !cmd_act_o && resp_lat_o == LAT_W'(HIT_LAT));

  a_r2_empty_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o == 2'd1 |-> cmd_act_o && !cmd_pre_o && resp_lat_o == LAT_W'(EMPTY_LAT));

  a_r3_conf_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o == 2'd2 |-> cmd_pre_o && resp_lat_o == LAT_W'(CONF_LAT));

  a_r3_pre_then_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pre_o |=> cmd_act_o && !cmd_pre_o);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_pre_o && cmd_act_o));

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  a_r6_busy_on_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> busy_o);

  a_r6_drop_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i |=> !resp_valid_o);

  a_r7_hit_le_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_hit_o <= cnt_req_o && cnt_conf_o <= cnt_req_o);

  a_r7_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_req_o >= $past(cnt_req_o));

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cnt_req_o && !clr_i |=> &cnt_req_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_req_o == '0 && cnt_hit_o == '0 && cnt_conf_o == '0);
endmodule

bind row_hit_monitor rhm_checker #(
  .CNT_W(CNT_W), .LAT_W(LAT_W), .HIT_LAT(HIT_LAT), .EMPTY_LAT(EMPTY_LAT), .CONF_LAT(CONF_LAT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .resp_valid_o (resp_valid_o),
  .resp_kind_o  (resp_kind_o),
  .resp_lat_o   (resp_lat_o),
  .cmd_pre_o    (cmd_pre_o),
  .cmd_act_o    (cmd_act_o),
  .cnt_req_o    (cnt_req_o),
  .cnt_hit_o    (cnt_hit_o),
  .cnt_conf_o   (cnt_conf_o)
);

// File: tb/tb_row_hit_monitor.sv
module tb_row_hit_monitor;
  localparam int NB = 8;
  localparam int RW = 14;
  localparam int CW = 4;  // narrow counters so saturation is reached
  localparam int CMAX = (1 << CW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0, req_valid_i = 1'b0;
  logic [2:0] req_bank_i = '0;
  logic [RW-1:0] req_row_i = '0;
  logic busy_o, resp_valid_o, cmd_pre_o, cmd_act_o;
  logic [1:0] resp_kind_o;
  logic [3:0] resp_lat_o;
  logic [2:0] cmd_bank_o;
  logic [RW-1:0] cmd_row_o;
  logic [CW-1:0] cnt_req_o, cnt_hit_o, cnt_conf_o;

  row_hit_monitor #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW)) dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, cycles = 0;
  bit m_open [NB];
  int m_row  [NB];
  int m_req = 0, m_hit = 0, m_conf = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int classify(input int b, input int r);
    if (!m_open[b]) return 1;
    if (m_row[b] == r) return 0;
    return 2;
  endfunction

  function automatic int lat_of(input int k);
    return (k == 0) ? 3 : (k == 1) ? 6 : 10;
  endfunction

  function automatic int sat_inc(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic chk_counts(input string tag);
    chk(int'(cnt_req_o) == m_req, tag, "cnt_req", int'(cnt_req_o), m_req);
    chk(int'(cnt_hit_o) == m_hit, tag, "cnt_hit", int'(cnt_hit_o), m_hit);
    chk(int'(cnt_conf_o) == m_conf, tag, "cnt_conf", int'(cnt_conf_o), m_conf);
  endtask

  task automatic do_req(input int b, input int r, input bit poke, input bit with_clr);
    int k, l, nb;
    string tk;
    while (busy_o) @(negedge clk_i);
    k = classify(b, r);
    l = lat_of(k);
    tk = (k == 0) ? "R1" : (k == 1) ? "R2" : "R3";
    req_valid_i = 1'b1; req_bank_i = 3'(b); req_row_i = RW'(r); clr_i = with_clr;
    @(negedge clk_i);
    req_valid_i = 1'b0; clr_i = 1'b0;
    m_open[b] = 1'b1; m_row[b] = r;
    if (with_clr) begin
      m_req = 0; m_hit = 0; m_conf = 0;
    end else begin
      m_req = sat_inc(m_req);
      if (k == 0) m_hit = sat_inc(m_hit);
      if (k == 2) m_conf = sat_inc(m_conf);
    end
    chk(resp_valid_o == 1'b1, "R5", "resp_valid", int'(resp_valid_o), 1);
    chk(int'(resp_kind_o) == k, tk, "kind", int'(resp_kind_o), k);
    chk(int'(resp_lat_o) == l, tk, "latency", int'(resp_lat_o), l);
    chk(cmd_pre_o == (k == 2), tk, "pre", int'(cmd_pre_o), int'(k == 2));
    chk(cmd_act_o == (k == 1), tk, "act", int'(cmd_act_o), int'(k == 1));
    if (k != 0) begin
      chk(int'(cmd_bank_o) == b, tk, "cmd_bank", int'(cmd_bank_o), b);
      chk(int'(cmd_row_o) == r, tk, "cmd_row", int'(cmd_row_o), r);
    end
    chk_counts(with_clr ? "R9" : (m_req == CMAX ? "R8" : "R7"));
    nb = busy_o ? 1 : 0;
    if (poke) begin  // dropped request (R6)
      req_valid_i = 1'b1; req_bank_i = 3'((b + 1) % NB); req_row_i = RW'(r ^ 5);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(resp_valid_o == 1'b0, poke ? "R6" : "R5", "resp_valid second cycle", int'(resp_valid_o), 0);
    chk(cmd_act_o == (k == 2), "R3", "act after pre", int'(cmd_act_o), int'(k == 2));
    chk(cmd_pre_o == 1'b0, "R3", "pre second cycle", int'(cmd_pre_o), 0);
    if (poke) chk_counts("R6");
    while (busy_o && nb < 40) begin
      nb++;
      @(negedge clk_i);
    end
    chk(nb == l, "R6", "busy length", nb, l);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd42));
    for (int i = 0; i < NB; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(busy_o == 1'b0, "R10", "busy", int'(busy_o), 0);
    chk(resp_valid_o == 1'b0, "R10", "resp_valid", int'(resp_valid_o), 0);
    chk(!cmd_pre_o && !cmd_act_o, "R10", "commands", int'({cmd_pre_o, cmd_act_o}), 0);
    chk_counts("R10");

    do_req(0, 5, 0, 0);   // R2 empty
    do_req(0, 5, 0, 0);   // R1 hit
    do_req(0, 9, 0, 0);   // R3 conflict
    do_req(1, 9, 0, 0);   // R4 other bank: empty, not conflict
    do_req(0, 9, 0, 0);   // R4 bank 0 undisturbed: hit
    do_req(2, 7, 1, 0);   // R6 poke into bank 3 while busy
    do_req(3, 100, 0, 0); // R6 bank 3 must still be empty
    do_req(3, 100, 0, 1); // R9 clear wins over same-cycle increment
    do_req(3, 100, 0, 0); // R9 table kept: hit

    for (int n = 0; n < 250; n++)
      do_req(int'($urandom % NB), int'($urandom % 3), (n % 37) == 5, 0);

    // R8 saturation reached after random traffic
    chk(int'(cnt_req_o) == CMAX, "R8", "cnt_req saturated", int'(cnt_req_o), CMAX);

    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    m_req = 0; m_hit = 0; m_conf = 0;
    chk_counts("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule